// File: doc/BRIEF.md
# Coprocessor Operand Bus Master Engine

This engine moves one multi-byte memory operand for a coprocessor that cannot form effective addresses itself. After the coprocessor issues a command (load or store, plus a length code), the engine watches the host's bus status. The host runs a dummy read cycle for the instruction. From that cycle the engine takes the operand address off the multiplexed address/data bus. On a load it also keeps the word that memory returns as operand word 0.

The engine then asks for the local bus with a one-clock request pulse on the request/grant handshake and waits for the host's one-clock grant pulse. It then runs its own memory cycles with an incrementing address until the operand is complete, and hands the bus back with a one-clock release pulse. Loaded words go into an operand buffer through a write port. Stored words come from the same buffer through a read port. BUSY stays high from the command until the bus has been released.

Top module: `opbm_engine`

## Requirements
- R1: Out of reset, BUSY, the request/grant output and every bus output enable are low, and the upper status lines read 0000.
- R2: The operand address is the address on the bus in the first clock of the first host read cycle (status 101 after passive 111) that follows a command. Host read cycles seen with no command pending are ignored, and BUSY stays low.
- R3: On a load, the data on the bus at the clock that ends the dummy read (READY high in T3) is written as operand buffer word 0. Any data present while READY is low is not taken.
- R4: On a store, the data of the dummy read is discarded. Every operand word, from buffer index 0 upward, is written to memory starting at the captured address.
- R5: The request pulse is one clock wide and comes in the clock after the dummy cycle's T4. The engine drives no bus output until a grant pulse, and its first own T1 is the clock after that grant.
- R6: While the engine owns the bus, its three-bit status is 101 (read) or 110 (write) during T1 to T3 and 111 (passive) otherwise. It never drives 100 or any code with bit 2 low.
- R7: While the engine owns the bus, the four upper status lines {S6,S5,S4,S3} read 1011. At all other times they read 0000.
- R8: An own bus cycle is T1, T2, T3 and T4, four clocks at zero wait states, and back-to-back cycles start every four clocks. Each clock with READY low at the end of T3 adds one T3 clock.
- R9: Length code 0, 1, 2 or 3 selects 2, 4, 8 or 10 bytes, with one byte per bus word at the default 8-bit data width. Own cycles step the address by one word per cycle and stop once the operand is complete: N-1 cycles for a load (starting at address+1), N cycles for a store.
- R10: After the last own cycle's T4, the engine emits one release pulse of one clock and stops driving the bus.
- R11: BUSY is high from the clock after the command until the clock after the release pulse, and then drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | One-clock command strobe |
| cmd_store_i | input | 1 | 1 = store operand to memory, 0 = load |
| cmd_len_i | input | 2 | Operand length code (2/4/8/10 bytes) |
| busy_o | output | 1 | High while an operand transfer is in progress |
| sts_i | input | 3 | Host bus-cycle status being snooped |
| ad_i | input | ADDR_W | Multiplexed address/data bus, input side |
| ready_i | input | 1 | Memory ready; low inserts wait states |
| ad_o | output | ADDR_W | Multiplexed address/data bus, driven side |
| ad_oe_o | output | 1 | Enable for ad_o |
| sts_o | output | 3 | Engine bus-cycle status |
| sts_oe_o | output | 1 | Enable for sts_o (engine owns the bus) |
| stat_hi_o | output | 4 | Upper status lines {S6,S5,S4,S3} |
| rq_o | output | 1 | Request and release pulses |
| gt_i | input | 1 | Grant pulse from the host |
| buf_we_o | output | 1 | Operand buffer write enable (loads) |
| buf_idx_o | output | IDX_W | Operand buffer word index |
| buf_wdata_o | output | DATA_W | Operand buffer write data |
| buf_rdata_i | input | DATA_W | Operand buffer read data (stores) |

## Verification
An 8-byte load with a stray host read before the command shows that capture waits for a command. It also shows that word 0 comes from the dummy cycle and the rest from the engine's own cycles, at addresses one above the snooped one. A 10-byte store whose dummy data is a distinctive marker shows that snooped data never reaches memory and that all ten words are written, and none beyond. A 2-byte load whose dummy cycle has a wait state, with wrong data during the wait, shows that data is sampled only when READY is high. A 4-byte store with READY held low through the first own cycle tells wait-state stretching apart from the four-clock spacing of the cycles that follow.

// File: rtl/opbm_pkg.sv
package opbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_SNOOP, ST_REQ, ST_WGT, ST_OWN, ST_REL
  } eng_state_e;

  typedef enum logic [1:0] {PH_T1, PH_T2, PH_T3, PH_T4} tphase_e;

  localparam logic [2:0] BS_READ    = 3'b101;
  localparam logic [2:0] BS_WRITE   = 3'b110;
  localparam logic [2:0] BS_PASSIVE = 3'b111;
  localparam logic [3:0] HI_OWN     = 4'b1011;

  function automatic int unsigned len_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 2;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/opbm_tstate.sv
module opbm_tstate
  import opbm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  tphase_e start_ph,
  input  logic    cont,
  input  logic    ready_i,
  output logic    act,
  output tphase_e ph,
  output logic    strobe,
  output logic    last
);

  logic    act_n;
  tphase_e ph_n;

  always_comb begin
    act_n = act;
    ph_n  = ph;
    if (!act) begin
      if (start) begin
        act_n = 1'b1;
        ph_n  = start_ph;
      end
    end else begin
      case (ph)
        PH_T1: ph_n = PH_T2;
        PH_T2: ph_n = PH_T3;
        PH_T3: if (ready_i) ph_n = PH_T4;
        default: begin
          if (cont) ph_n = PH_T1;
          else      act_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      ph  <= PH_T1;
    end else begin
      act <= act_n;
      ph  <= ph_n;
    end
  end

  assign strobe = act && (ph == PH_T3) && ready_i;
  assign last   = act && (ph == PH_T4);

  // R8: a T3 with READY low repeats
  assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act && ph == PH_T3 && !ready_i) |=> (act && ph == PH_T3));

  // R8: T1 is always followed by T2
  assert_t1_t2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act && ph == PH_T1) |=> (act && ph == PH_T2));

endmodule

// File: rtl/opbm_addr.sv
module opbm_addr #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned STEP   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_n;
  logic              addr_en;

  always_comb begin
    addr_en = load || inc;
    addr_n  = load ? ld_val : addr + ADDR_W'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (addr_en) addr <= addr_n;
  end

endmodule

// File: rtl/opbm_engine.sv
module opbm_engine
  import opbm_pkg::*;
#(
  parameter  int unsigned ADDR_W = 20,
  parameter  int unsigned DATA_W = 8,
  localparam int unsigned BPW    = DATA_W / 8,
  localparam int unsigned MAXW   = (10 + BPW - 1) / BPW,
  localparam int unsigned IDX_W  = $clog2(MAXW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic              cmd_store_i,
  input  logic [1:0]        cmd_len_i,
  output logic              busy_o,
  input  logic [2:0]        sts_i,
  input  logic [ADDR_W-1:0] ad_i,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [2:0]        sts_o,
  output logic              sts_oe_o,
  output logic [3:0]        stat_hi_o,
  output logic              rq_o,
  input  logic              gt_i,
  output logic              buf_we_o,
  output logic [IDX_W-1:0]  buf_idx_o,
  output logic [DATA_W-1:0] buf_wdata_o,
  input  logic [DATA_W-1:0] buf_rdata_i
);

  eng_state_e        state, state_n;
  logic [2:0]        sts_prev;
  logic              store_q, store_n;
  logic [IDX_W-1:0]  nwords_q, nwords_n, idx_q, idx_n, words_c;
  logic              ctl_en;

  logic              t_act, t_strobe, t_last, t_start, t_cont;
  tphase_e           t_ph, t_start_ph;
  logic              snoop_t1, own, more, addr_inc;
  logic [ADDR_W-1:0] addr;

  always_comb begin
    words_c = IDX_W'((len_bytes(cmd_len_i) + BPW - 1) / BPW);
  end

  assign snoop_t1 = (state == ST_ARM) && (sts_i == BS_READ) && (sts_prev == BS_PASSIVE);
  assign own      = (state == ST_OWN);
  assign more     = (idx_q + IDX_W'(1)) < nwords_q;

  assign t_start    = snoop_t1 || ((state == ST_WGT) && gt_i);
  assign t_start_ph = snoop_t1 ? PH_T2 : PH_T1;
  assign t_cont     = own && more;

  opbm_tstate u_tstate (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (t_start),
    .start_ph (t_start_ph),
    .cont     (t_cont),
    .ready_i  (ready_i),
    .act      (t_act),
    .ph       (t_ph),
    .strobe   (t_strobe),
    .last     (t_last)
  );

  assign addr_inc = t_last && ((own) || ((state == ST_SNOOP) && !store_q));

  opbm_addr #(.ADDR_W(ADDR_W), .STEP(BPW)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (snoop_t1),
    .ld_val (ad_i),
    .inc    (addr_inc),
    .addr   (addr)
  );

  // next-state
  always_comb begin
    state_n  = state;
    store_n  = store_q;
    nwords_n = nwords_q;
    idx_n    = idx_q;
    case (state)
      ST_IDLE: if (cmd_valid_i) begin
        state_n  = ST_ARM;
        store_n  = cmd_store_i;
        nwords_n = words_c;
        idx_n    = '0;
      end
      ST_ARM:   if (snoop_t1) state_n = ST_SNOOP;
      ST_SNOOP: if (t_last) begin
        if (store_q) state_n = ST_REQ;
        else begin
          idx_n   = IDX_W'(1);
          state_n = (nwords_q == IDX_W'(1)) ? ST_IDLE : ST_REQ;
        end
      end
      ST_REQ:   state_n = ST_WGT;
      ST_WGT:   if (gt_i) state_n = ST_OWN;
      ST_OWN:   if (t_last) begin
        if (more) idx_n   = idx_q + IDX_W'(1);
        else      state_n = ST_REL;
      end
      default:  state_n = ST_IDLE;
    endcase
    ctl_en = (state_n != state) || (idx_n != idx_q) ||
             (store_n != store_q) || (nwords_n != nwords_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      store_q  <= 1'b0;
      nwords_q <= '0;
      idx_q    <= '0;
    end else if (ctl_en) begin
      state    <= state_n;
      store_q  <= store_n;
      nwords_q <= nwords_n;
      idx_q    <= idx_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_prev <= BS_PASSIVE;
    else        sts_prev <= sts_i;
  end

  // outputs
  assign busy_o      = (state != ST_IDLE);
  assign rq_o        = (state == ST_REQ) || (state == ST_REL);
  assign sts_oe_o    = own;
  assign sts_o       = (own && t_act && t_ph != PH_T4) ? (store_q ? BS_WRITE : BS_READ)
                                                        : BS_PASSIVE;
  assign stat_hi_o   = own ? HI_OWN : 4'b0000;
  assign ad_oe_o     = own && t_act && ((t_ph == PH_T1) || store_q);
  assign ad_o        = (t_ph == PH_T1) ? addr : ADDR_W'(buf_rdata_i);
  assign buf_we_o    = t_strobe && !store_q && ((state == ST_SNOOP) || own);
  assign buf_idx_o   = idx_q;
  assign buf_wdata_o = ad_i[DATA_W-1:0];

  // R6: only legal codes while owning the bus
  assert_sts_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sts_oe_o |-> (sts_o[2] && sts_o != 3'b100));

  // R7: upper status lines while owning the bus
  assert_hi_own_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_oe_o |-> (stat_hi_o == HI_OWN));

  // R5, R10: request and release pulses are one clock wide
  assert_rq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rq_o |=> !rq_o);

  // R11: for a store, BUSY falls only after a release pulse
  assert_busy_after_rel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && $past(store_q)) |-> $past(rq_o));

endmodule

// File: tb/test_opbm_engine.sv
`timescale 1ns/1ps
module test_opbm_engine;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_store;
  logic [1:0] cmd_len;
  logic busy;
  logic [2:0] sts_i;
  logic [ADDR_W-1:0] host_ad, ad_i, ad_o;
  logic ready, ad_oe, sts_oe, rq, gt, buf_we;
  logic [2:0] sts_o;
  logic [3:0] stat_hi;
  logic [IDX_W-1:0] buf_idx;
  logic [DATA_W-1:0] buf_wdata, buf_rdata;

  logic [7:0] mem [0:255];
  logic [7:0] opbuf [0:15];
  logic [7:0] m_addr;

  int nchk = 0, nfail = 0;
  int cyc_no = 0;
  int mon_n;
  int cyc_len [0:15];
  int cyc_t1 [0:15];
  logic [ADDR_W-1:0] cyc_addr [0:15];
  logic [2:0] cyc_code [0:15];
  int run_len, bad_code, hi_bad;
  logic mon_prev;
  logic [2:0] cur_code;

  always #2 clk = ~clk;

  assign ad_i = sts_oe ? ADDR_W'(mem[m_addr]) : host_ad;
  assign buf_rdata = opbuf[buf_idx];

  always @(posedge clk) if (buf_we) opbuf[buf_idx] <= buf_wdata;

  opbm_engine i_opbm_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_store_i(cmd_store),
    .cmd_len_i(cmd_len), .busy_o(busy), .sts_i(sts_i), .ad_i(ad_i), .ready_i(ready),
    .ad_o(ad_o), .ad_oe_o(ad_oe), .sts_o(sts_o), .sts_oe_o(sts_oe), .stat_hi_o(stat_hi),
    .rq_o(rq), .gt_i(gt), .buf_we_o(buf_we), .buf_idx_o(buf_idx),
    .buf_wdata_o(buf_wdata), .buf_rdata_i(buf_rdata)
  );

  // memory model and bus monitor
  always @(negedge clk) begin
    logic act;
    cyc_no++;
    act = sts_oe && (sts_o == 3'b101 || sts_o == 3'b110);
    if (sts_oe && !(sts_o == 3'b101 || sts_o == 3'b110 || sts_o == 3'b111)) bad_code++;
    if (sts_oe && stat_hi != 4'b1011) hi_bad++;
    if (act && !mon_prev) begin
      m_addr = ad_o[7:0];
      cur_code = sts_o;
      run_len = 1;
      if (mon_n < 16) begin
        cyc_t1[mon_n] = cyc_no;
        cyc_addr[mon_n] = ad_o;
      end
    end else if (act) run_len++;
    if (!act && mon_prev) begin
      if (mon_n < 16) begin
        cyc_len[mon_n] = run_len;
        cyc_code[mon_n] = cur_code;
      end
      if (cur_code == 3'b110 && ad_oe) mem[m_addr] = ad_o[7:0];
      mon_n++;
    end
    mon_prev = act;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act_v, input int exp_v);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic host_read(input logic [ADDR_W-1:0] a, input logic [7:0] d, input bit wait1);
    @(negedge clk); sts_i = 3'b101; host_ad = a; ready = 1'b1;
    @(negedge clk); host_ad = wait1 ? ADDR_W'(8'h5A) : ADDR_W'(d); ready = !wait1;
    if (wait1) begin
      @(negedge clk); host_ad = ADDR_W'(8'h5A); ready = 1'b0;
    end
    @(negedge clk); host_ad = ADDR_W'(d); ready = 1'b1;
    @(negedge clk); sts_i = 3'b111; host_ad = '0;
  endtask

  // command, dummy cycle, handshake, own cycles, release
  task automatic run_op(input bit store, input logic [1:0] len, input logic [ADDR_W-1:0] a,
                        input logic [7:0] dummy, input bit dwait, input bit owait);
    int waited;
    mon_n = 0; bad_code = 0; hi_bad = 0;
    @(negedge clk); cmd_valid = 1'b1; cmd_store = store; cmd_len = len;
    @(negedge clk); cmd_valid = 1'b0;
    chk(busy == 1'b1, "R11", "busy after command", busy, 1);
    host_read(a, dummy, dwait);
    // first negedge after the dummy T4
    @(negedge clk);
    chk(rq == 1'b1, "R5", "request right after dummy cycle", rq, 1);
    @(negedge clk);
    chk(rq == 1'b0, "R5", "request pulse width", rq, 0);
    @(negedge clk);
    chk(!sts_oe && !ad_oe, "R5", "no drive before grant", {sts_oe, ad_oe}, 0);
    gt = 1'b1;
    @(negedge clk); gt = 1'b0;
    chk(sts_oe && sts_o == (store ? 3'b110 : 3'b101) && ad_oe && ad_o == a + (store ? 0 : 1),
        "R5", "first T1 after grant", {sts_o, ad_o}, {store ? 3'b110 : 3'b101, a + (store ? 0 : 1)});
    if (owait) begin
      ready = 1'b0;
      repeat (5) @(negedge clk);
      ready = 1'b1;
    end
    waited = 0;
    while (!rq && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    chk(rq && busy, "R10", "release pulse while busy", {rq, busy}, 3);
    @(negedge clk);
    chk(!rq && !busy && !sts_oe && !ad_oe && stat_hi == 4'b0000, "R11",
        "idle after release", {rq, busy, sts_oe, ad_oe}, 0);
    chk(bad_code == 0, "R6", "illegal status codes", bad_code, 0);
    chk(hi_bad == 0, "R7", "upper status while owning", hi_bad, 0);
  endtask

  task automatic check_cycles(input int n, input logic [ADDR_W-1:0] a0,
                              input logic [2:0] code, input int first_len);
    int bad;
    chk(mon_n == n, "R9", "own cycle count", mon_n, n);
    bad = 0;
    for (int k = 0; k < n && k < 16; k++)
      if (cyc_addr[k] != a0 + k || cyc_code[k] != code) bad++;
    chk(bad == 0, "R9", "address step and code", bad, 0);
    bad = 0;
    for (int k = 0; k < n && k < 16; k++) begin
      if (cyc_len[k] != ((k == 0) ? first_len : 3)) bad++;
      if (k > 0 && cyc_t1[k] - cyc_t1[k-1] != ((k == 1) ? first_len + 1 : 4)) bad++;
    end
    chk(bad == 0, "R8", "cycle length and spacing", bad, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !rq && !ad_oe && !sts_oe && stat_hi == 4'b0000, "R1", "reset state",
        {busy, rq, ad_oe, sts_oe, stat_hi}, 0);
  endtask

  task automatic t_load8;
    int bad;
    for (int i = 0; i < 16; i++) opbuf[i] = 8'h00;
    host_read(20'h00020, 8'h99, 1'b0);
    @(negedge clk);
    chk(!busy, "R2", "host read without command ignored", busy, 0);
    run_op(1'b0, 2'd2, 20'h00040, mem[8'h40], 1'b0, 1'b0);
    chk(opbuf[0] == mem[8'h40], "R3", "word 0 from dummy cycle", opbuf[0], mem[8'h40]);
    bad = 0;
    for (int i = 1; i < 8; i++) if (opbuf[i] != mem[8'h40 + i]) bad++;
    chk(bad == 0, "R9", "load bytes 1..7", bad, 0);
    chk(opbuf[8] == 8'h00, "R9", "no extra load word", opbuf[8], 0);
    check_cycles(7, 20'h00041, 3'b101, 3);
  endtask

  task automatic t_store10;
    int bad;
    logic [7:0] after;
    for (int i = 0; i < 16; i++) opbuf[i] = 8'hA0 + 8'(i);
    after = mem[8'h8A];
    run_op(1'b1, 2'd3, 20'h00080, 8'hEE, 1'b0, 1'b0);
    chk(mem[8'h80] == 8'hA0, "R4", "dummy data not stored", mem[8'h80], 8'hA0);
    bad = 0;
    for (int i = 0; i < 10; i++) if (mem[8'h80 + i] != 8'hA0 + 8'(i)) bad++;
    chk(bad == 0, "R4", "store bytes 0..9", bad, 0);
    chk(mem[8'h8A] == after, "R9", "no write past operand", mem[8'h8A], after);
    check_cycles(10, 20'h00080, 3'b110, 3);
  endtask

  task automatic t_load2_wait;
    for (int i = 0; i < 16; i++) opbuf[i] = 8'h00;
    run_op(1'b0, 2'd0, 20'h00010, mem[8'h10], 1'b1, 1'b0);
    chk(opbuf[0] == mem[8'h10], "R3", "dummy data taken only with READY", opbuf[0], mem[8'h10]);
    chk(opbuf[1] == mem[8'h11], "R9", "second byte of 2-byte load", opbuf[1], mem[8'h11]);
    check_cycles(1, 20'h00011, 3'b101, 3);
  endtask

  task automatic t_store4_wait;
    int bad;
    for (int i = 0; i < 16; i++) opbuf[i] = 8'h30 + 8'(i);
    run_op(1'b1, 2'd1, 20'h00060, 8'hEE, 1'b0, 1'b1);
    bad = 0;
    for (int i = 0; i < 4; i++) if (mem[8'h60 + i] != 8'h30 + 8'(i)) bad++;
    chk(bad == 0, "R4", "store bytes with wait states", bad, 0);
    chk(cyc_len[0] == 6, "R8", "three wait states stretch T3", cyc_len[0], 6);
    check_cycles(4, 20'h00060, 3'b110, 6);
  endtask

  initial begin
    #400000;
    nfail++;
    $display("FAIL R11 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
    m_addr = '0; mon_n = 0; mon_prev = 1'b0; cur_code = 3'b111;
    run_len = 0; bad_code = 0; hi_bad = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_store = 1'b0; cmd_len = 2'd0;
    sts_i = 3'b111; host_ad = '0; ready = 1'b1; gt = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_load8();
    t_store10();
    t_load2_wait();
    t_store4_wait();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule